// File: doc/BRIEF.md
# One-Shot Interval Timer with Interrupt Flag

This block is a 16-bit down-counting interval timer with one interrupt source, an interrupt enable mask and an active-low interrupt request. A processor reaches it over an 8-bit register bus with a chip select, a register address, read and write strobes, and separate read and write data. Software stages the low byte of a count and then writes the high byte. That write loads the counter, starts it and arms a one-shot timeout flag. The flag rises once, on the clock edge where the counter passes from zero to all ones. The counter then keeps running down and is never reloaded, so reading the high byte shows its top bit set once the interval has passed.

There are two ways to drop the flag without re-arming: read the count low byte, or write a 1 to the flag's bit in the flag register. A flag dropped this way after a timeout stays low until the next high-byte write, however many times the counter wraps. The interrupt request follows the enabled flags.

The register bus is a plain strobe interface with no valid/ready pair. Every access completes in the cycle it is presented and can never be back-pressured. Only the low four address bits are decoded, so the whole address window is filled with repeats of the same sixteen register slots.

Top module: `oneshot_tmr`

## Requirements
- R1: An access takes effect only with `cs` high. Only `addr[3:0]` selects the register, so every address with the same low nibble reaches the same register. Slots other than 8, 9, B, D and E read as 0, and writes to them have no effect.
- R2: A write to slot 8 stores the byte in a staging latch and leaves the running counter unchanged.
- R3: A write of byte H to slot 9 loads the counter with {H, latch}, clears the timeout flag and arms it. From the next edge on, the counter drops by one per clock. If N was loaded, the flag reads 1 after N+1 further clock edges and reads 0 after N of them.
- R4: The flag rises at most once per arming. After a timeout the counter keeps decrementing through zero with no reload, so a load of 0x3075 reads back with a high byte of 0xFF one cycle after the timeout.
- R5: A read of slot 8 returns the counter low byte and clears the flag without re-arming.
- R6: A write to slot D with bit 5 set clears the flag without re-arming. The same write with bit 5 clear has no effect on the flag.
- R7: Once the flag has been cleared by R5 or R6 after a timeout, it stays 0 through any number of counter wraps until the next slot 9 write.
- R8: A read of slot D returns the flag in bit 5, zeros in bits 6 and 4..0, and in bit 7 the OR of the enabled flags. `irq_n` is low exactly when that bit 7 is 1.
- R9: A write to slot E with bit 7 = 1 sets the enable bits marked by 1s in bits 6..0. With bit 7 = 0 it clears those bits instead. A read of slot E returns the enables with bit 7 forced to 1, and the enables reset to 0.
- R10: Slot B is a read/write mode byte that resets to 0. While its bit 5 is 1 the counter holds its value, so no timeout can occur. Bit 5 = 0 selects the one-shot count-down (for example 0x98).
- R11: A read of slot 9 returns the counter high byte and has no effect on the flag.
- R12: If a timeout and a non-arming clear fall on the same clock edge, the timeout wins and the flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, qualifies every access |
| addr | input | ADDR_W | Register address; only bits 3..0 are decoded |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, 0 when no read is selected |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its defaults: an 11-bit address and an 8-bit data bus, which gives a 16-bit counter. The 11-bit address lets a single sweep read all 2048 addresses of the window and compare each against the value its low nibble should select. The 16-bit counter lets the bench wait one full wrap (65,536 cycles) after a cleared timeout, and it loads every count from 0 to 40 to place the flag's rising edge to the exact cycle.

// File: rtl/oneshot_tmr_pkg.sv
`timescale 1ns/1ps
package oneshot_tmr_pkg;

  localparam int REG_SEL_W = 4;
  localparam int T2_BIT    = 5;

  typedef enum logic [REG_SEL_W-1:0] {
    SLOT_CNT_LO = 4'h8,
    SLOT_CNT_HI = 4'h9,
    SLOT_MODE   = 4'hB,
    SLOT_FLAGS  = 4'hD,
    SLOT_ENABLE = 4'hE
  } reg_slot_e;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
    logic lo_rd;
    logic mode_wr;
    logic flags_wr;
    logic enable_wr;
  } bus_strobe_t;

endpackage

// File: rtl/tmr_bus_decode.sv
`timescale 1ns/1ps
module tmr_bus_decode
  import oneshot_tmr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                 cs,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [REG_SEL_W-1:0] sel,
  output bus_strobe_t          stb
);
  // Upper address bits alias onto the same sixteen slots.
  logic unused_upper;
  assign unused_upper = ^addr[ADDR_W-1:REG_SEL_W];
  assign sel = addr[REG_SEL_W-1:0];

  logic wr_q, rd_q;
  assign wr_q = cs && wr;
  assign rd_q = cs && rd;

  always_comb begin
    stb           = '0;
    stb.lo_wr     = wr_q && (sel == SLOT_CNT_LO);
    stb.hi_wr     = wr_q && (sel == SLOT_CNT_HI);
    stb.mode_wr   = wr_q && (sel == SLOT_MODE);
    stb.flags_wr  = wr_q && (sel == SLOT_FLAGS);
    stb.enable_wr = wr_q && (sel == SLOT_ENABLE);
    stb.lo_rd     = rd_q && (sel == SLOT_CNT_LO);
  end
endmodule

// File: rtl/tmr_t2_core.sv
`timescale 1ns/1ps
module tmr_t2_core #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              lo_rd,
  input  logic              flag_clr,
  input  logic              hold,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              flag,
  output logic              armed
);
  logic [DATA_W-1:0] latch_q;
  logic              timeout;

  // Timeout is the armed pass from zero to all ones.
  assign timeout = armed && !hold && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt     <= '0;
      armed   <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (lo_wr) latch_q <= wdata;
      if (hi_wr) begin
        cnt   <= {wdata, latch_q};
        armed <= 1'b1;
        flag  <= 1'b0;
      end else begin
        if (!hold) cnt <= cnt - 1'b1;
        if (timeout) begin
          flag  <= 1'b1;
          armed <= 1'b0;
        end else if (lo_rd || flag_clr) begin
          flag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
`timescale 1ns/1ps
module tmr_irq_ctrl
  import oneshot_tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SRC_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              t2_flag,
  output logic [SRC_W-1:0]  ien,
  output logic [DATA_W-1:0] flags_byte,
  output logic              irq_n
);
  logic [SRC_W-1:0] src;
  logic             any_active;

  always_comb begin
    src         = '0;
    src[T2_BIT] = t2_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
    end else if (enable_wr) begin
      if (wdata[DATA_W-1]) ien <= ien | wdata[SRC_W-1:0];
      else                 ien <= ien & ~wdata[SRC_W-1:0];
    end
  end

  assign any_active = |(src & ien);
  assign flags_byte = {any_active, src};
  assign irq_n      = !any_active;
endmodule

// File: rtl/oneshot_tmr.sv
`timescale 1ns/1ps
module oneshot_tmr
  import oneshot_tmr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);
  localparam int CNT_W = 2 * DATA_W;

  logic [REG_SEL_W-1:0] sel;
  bus_strobe_t          stb;
  logic [DATA_W-1:0]    mode_q;
  logic [CNT_W-1:0]     t2_cnt;
  logic                 t2_flag;
  logic                 t2_armed;
  logic [DATA_W-2:0]    ien_q;
  logic [DATA_W-1:0]    flags_byte;

  tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs(cs), .addr(addr), .rd(rd), .wr(wr), .sel(sel), .stb(stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= '0;
    else if (stb.mode_wr) mode_q <= wdata;
  end

  tmr_t2_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(stb.lo_wr), .hi_wr(stb.hi_wr), .lo_rd(stb.lo_rd),
    .flag_clr(stb.flags_wr && wdata[T2_BIT]),
    .hold(mode_q[T2_BIT]), .wdata(wdata),
    .cnt(t2_cnt), .flag(t2_flag), .armed(t2_armed)
  );

  tmr_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .enable_wr(stb.enable_wr), .wdata(wdata), .t2_flag(t2_flag),
    .ien(ien_q), .flags_byte(flags_byte), .irq_n(irq_n)
  );

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      case (sel)
        SLOT_CNT_LO: rdata = t2_cnt[DATA_W-1:0];
        SLOT_CNT_HI: rdata = t2_cnt[CNT_W-1:DATA_W];
        SLOT_MODE:   rdata = mode_q;
        SLOT_FLAGS:  rdata = flags_byte;
        SLOT_ENABLE: rdata = {1'b1, ien_q};
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/oneshot_tmr_chk.sv
`timescale 1ns/1ps
module oneshot_tmr_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hi_wr,
  input logic              hold,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag,
  input logic              armed,
  input logic              ien_t2,
  input logic              irq_n
);
  localparam logic [CNT_W-1:0] ONE = 1;

  // R3: a high-byte write loads the top half, arms and clears the flag
  a_r3_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (cnt[CNT_W-1:DATA_W] == $past(wdata)) && armed && !flag);

  // R3 / R4: steady count-down with no reload
  a_r4_steady_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr && !hold) |=> cnt == $past(cnt) - ONE);

  // R4: the flag only rises from an armed zero crossing
  a_r4_rise_once: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(armed) && ($past(cnt) == '0)));

  // R7: a cleared, disarmed flag stays low without a new load
  a_r7_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !armed && !hi_wr) |=> !flag);

  // R10: the counter holds while the mode bit is set
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !hi_wr) |=> $stable(cnt));

  // R12: an armed zero crossing always raises the flag
  a_r12_timeout_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !hold && (cnt == '0) && !hi_wr) |=> flag);

  // R8: the request needs both flag and enable
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag && ien_t2));
endmodule

bind oneshot_tmr oneshot_tmr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_wr(stb.hi_wr), .hold(mode_q[5]),
  .wdata(wdata), .cnt(t2_cnt), .flag(t2_flag), .armed(t2_armed),
  .ien_t2(ien_q[5]), .irq_n(irq_n)
);

// File: tb/oneshot_tmr_tb.sv
`timescale 1ns/1ps
module oneshot_tmr_tb;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint cyc = 0;
  longint load_cyc = 0;
  int load_val = 0;

  always #4 clk = ~clk;

  oneshot_tmr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    cyc++;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    cyc++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    cyc += n;
  endtask

  task automatic load(input int n, input logic [ADDR_W-1:0] base);
    bus_wr(base | 11'h8, n[7:0]);
    bus_wr(base | 11'h9, n[15:8]);
    load_cyc = cyc;
    load_val = n;
  endtask

  function automatic int exp_cnt();
    return int'((longint'(load_val) - (cyc - load_cyc)) & 64'hFFFF);
  endfunction

  initial begin
    #1_700_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // Reset state: counter free-runs unarmed, so no flag
    check("R8 reset irq_n", irq_n, 1);
    bus_rd(11'h00D, d); check("R8 reset flags", d, 8'h00);
    bus_rd(11'h00E, d); check("R9 reset enables", d, 8'h80);
    bus_rd(11'h00B, d); check("R10 reset mode", d, 8'h00);

    bus_wr(11'h10E, 8'hA0);
    bus_rd(11'h00E, d); check("R9 enable set", d, 8'hA0);
    bus_wr(11'h7FB, 8'h98);
    bus_rd(11'h00B, d); check("R10 mode readback", d, 8'h98);

    // Sweep of small counts with exact timeout edge
    for (int n = 0; n <= 40; n++) begin
      logic [ADDR_W-1:0] base;
      base = ADDR_W'(n << 4);
      load(n, base);
      idle(n);
      check($sformatf("R3 n=%0d no flag yet", n), irq_n, 1);
      idle(1);
      check($sformatf("R3 n=%0d flag at N+1", n), irq_n, 0);
      bus_rd(base | 11'hD, d); check("R8 flags with enable", d, 8'hA0);
      e = exp_cnt();
      bus_rd(base | 11'h9, d); check("R4 high byte after timeout", d, e >> 8);
      check("R11 high read keeps flag", irq_n, 0);
      if (n % 2 == 0) begin
        bus_wr(base | 11'hD, 8'hDF);
        check("R6 bit5 clear ignored", irq_n, 0);
        bus_wr(base | 11'hD, 8'h20);
        check("R6 flag write clears", irq_n, 1);
      end else begin
        e = exp_cnt();
        bus_rd(base | 11'h8, d); check("R5 low byte value", d, e & 8'hFF);
        check("R5 low read clears", irq_n, 1);
      end
      bus_rd(base | 11'hD, d); check("R7 flags after clear", d, 8'h00);
    end

    // Same-edge timeout and clear
    load(6, 11'h000);
    idle(6);
    bus_rd(11'h008, d); check("R12 low at zero", d, 8'h00);
    check("R12 timeout beats low read", irq_n, 0);
    bus_wr(11'h00D, 8'h20);
    load(6, 11'h000);
    idle(6);
    bus_wr(11'h00D, 8'h20);
    check("R12 timeout beats flag write", irq_n, 0);
    bus_wr(11'h00D, 8'h20);

    // Cleared after timeout: stays low across a full wrap
    load(2, 11'h230);
    idle(3);
    check("R7 timed out", irq_n, 0);
    bus_wr(11'h00D, 8'h20);
    idle(65600);
    check("R7 still low after wrap", irq_n, 1);
    e = exp_cnt();
    bus_rd(11'h009, d); check("R4 no reload after wrap", d, e >> 8);

    // Long count runs through zero and shows the top bit
    load(16'h3075, 11'h450);
    idle(16'h3075 + 1);
    check("R4 long timeout", irq_n, 0);
    bus_rd(11'h009, d); check("R4 top bit set", d, 8'hFF);
    bus_wr(11'h00D, 8'h20);

    // Hold mode
    bus_wr(11'h00B, 8'h20);
    load(16'h1234, 11'h000);
    idle(20);
    bus_rd(11'h008, d); check("R10 held low", d, 8'h34);
    bus_rd(11'h009, d); check("R10 held high", d, 8'h12);
    load(0, 11'h000);
    idle(5);
    check("R10 no timeout when held", irq_n, 1);

    // Staging latch does not touch the counter
    bus_wr(11'h008, 8'h77);
    bus_rd(11'h008, d); check("R2 counter low unchanged", d, 8'h00);
    bus_wr(11'h009, 8'h01);
    bus_rd(11'h008, d); check("R2 latch into low", d, 8'h77);
    bus_rd(11'h009, d); check("R2 high loaded", d, 8'h01);
    load(0, 11'h000);

    // cs low write is ignored
    cs = 1'b0; wr = 1'b1; addr = 11'h009; wdata = 8'h55;
    @(negedge clk); wr = 1'b0; cyc++;
    bus_rd(11'h009, d); check("R1 no access without cs", d, 8'h00);

    // Full address-window sweep, counter held at 0
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      int ex;
      case (a & 15)
        4'hB: ex = 8'h20;
        4'hE: ex = 8'hA0;
        default: ex = 0;
      endcase
      bus_rd(ADDR_W'(a), d);
      check($sformatf("R1 alias addr 0x%0h", a), d, ex);
    end

    // Enable masking
    bus_wr(11'h00B, 8'h98);
    bus_wr(11'h00E, 8'h20);
    bus_rd(11'h00E, d); check("R9 enable clear", d, 8'h80);
    load(1, 11'h000);
    idle(2);
    check("R8 masked no irq", irq_n, 1);
    bus_rd(11'h00D, d); check("R8 masked flags", d, 8'h20);
    bus_wr(11'h00E, 8'hA0);
    check("R8 enabled irq", irq_n, 0);
    bus_rd(11'h00D, d); check("R8 enabled flags", d, 8'hA0);
    bus_wr(11'h00E, 8'hC3);
    bus_rd(11'h00E, d); check("R9 enable accumulate", d, 8'hE3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule